// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Aggregator

This block gathers five serious fault indications into one non-maskable interrupt request for a processor. The sources are a failing reference clock, a request arriving on an external pin, an error during an interrupt vector fetch, a reset of a peer processor caused by its watchdog, and a stuck handshake on the link between processors. Each source has a flag bit and an enable bit. A flag records that its event occurred, even while the source is disabled. The request output is raised while any flag that is enabled is still set.

Software clears flags by writing ones to them. It can switch sources on, but it can never switch them off again. Four sources come out of reset already enabled. The vector-fetch source is permanently enabled. The handshake source starts disabled and stays disabled until software enables it. The external pin is asynchronous and active high. It passes through a synchronizer and an edge detector, and it counts only while the pin's alternate function is selected. That selection is made by a protected configuration elsewhere and arrives here as a level.

Top module: `nmi_src_agg`

## Requirements
- R1: After reset, all flags are 0, the enable vector is 5'b01111 (only the handshake source is disabled), and `nmi_req` is 0.
- R2: Flag bit positions are fixed: bit 0 peer watchdog reset, bit 1 clock fail, bit 2 external pin, bit 3 vector-fetch error, bit 4 handshake stuck. An event input that is high at a rising clock edge sets its flag at that edge.
- R3: A flag is set by its event whether or not its enable bit is 1. A disabled flag does not raise `nmi_req`.
- R4: A write with `wr_sel`=0 clears every flag whose `wr_data` bit is 1 and leaves flags whose bit is 0 unchanged.
- R5: When an event and a clear of the same flag occur at the same edge, the flag stays 1.
- R6: A write with `wr_sel`=1 sets every enable bit whose `wr_data` bit is 1. An enable bit that is 1 never returns to 0 before reset, and writing 0 has no effect.
- R7: The vector-fetch enable (bit 3) is 1 at all times after reset.
- R8: `nmi_req` is 1 exactly when some flag and its enable are both 1. It stays high until every enabled flag has been cleared.
- R9: A rising edge on `pin_nmi` sets flag bit 2 at the third rising clock edge after the pin goes high (two synchronizer stages plus one edge stage). A pin held high sets the flag only once.
- R10: While `pin_alt_sel` is 0, edges on `pin_nmi` leave flag bit 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_peer_rst | input | 1 | Peer processor was reset by its watchdog |
| evt_clk_fail | input | 1 | Clock monitor reports a failure |
| evt_vec_err | input | 1 | Vector-fetch error |
| evt_link_stuck | input | 1 | Inter-processor handshake stuck |
| pin_nmi | input | 1 | Asynchronous external request, active high |
| pin_alt_sel | input | 1 | Pin alternate function selected |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 0: clear flags, 1: set enables |
| wr_data | input | 5 | Write data, one bit per source |
| nmi_req | output | 1 | Non-maskable interrupt request |
| flags | output | 5 | Source flags |
| enables | output | 5 | Source enables |

## Verification
Flags and enables are both visible at the ports, so a wrong internal state shows up one clock later as a mismatched bit on `flags` or `enables`, or as a wrong level on `nmi_req`. A lost flag, a flag cleared by the wrong mask, or a fresh event that loses to a clear all appear in the cycle after the edge concerned. The synchronizer's internal state is not visible directly. An error there shows up on flag bit 2 at the third edge after a pin change: the flag is late or early, or it is set more than once while the pin is held high. The bench compares all three outputs against its model on every cycle.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_PEER = 0;
  localparam int SRC_CLK  = 1;
  localparam int SRC_PIN  = 2;
  localparam int SRC_VEC  = 3;
  localparam int SRC_LINK = 4;
  localparam logic [NSRC-1:0] EN_RESET_VAL = 5'b01111;
  localparam logic [NSRC-1:0] EN_LOCK_MASK = 5'b01000;
  typedef enum logic {WR_FLAG_CLR = 1'b0, WR_EN_SET = 1'b1} wr_sel_e;
endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic upd, nxt, q;

    always_comb begin
      upd = evt[i] | clr[i];
      nxt = evt[i] | (q & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (upd) q <= nxt;
    end

    assign flag[i] = q;

    // R5
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
    // R4
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(clr[i]));
  end
endmodule

// File: rtl/nmi_enable_reg.sv
module nmi_enable_reg #(
  parameter int             N         = 5,
  parameter logic [N-1:0]   RST_VAL   = '1,
  parameter logic [N-1:0]   LOCK_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] en
);
  logic [N-1:0] en_q, en_d;
  logic         upd;

  always_comb begin
    upd  = |set;
    en_d = en_q | set | LOCK_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= RST_VAL | LOCK_MASK;
    else if (upd) en_q <= en_d;
  end

  assign en = en_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(en[i]));
  end
endmodule

// File: rtl/nmi_src_agg.sv
module nmi_src_agg
  import nmi_agg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_peer_rst,
  input  logic            evt_clk_fail,
  input  logic            evt_vec_err,
  input  logic            evt_link_stuck,
  input  logic            pin_nmi,
  input  logic            pin_alt_sel,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [NSRC-1:0] wr_data,
  output logic            nmi_req,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables
);
  logic            pin_rise;
  logic [NSRC-1:0] evt_vec, clr_vec, set_vec;

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_nmi), .rise(pin_rise)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[SRC_PEER] = evt_peer_rst;
    evt_vec[SRC_CLK]  = evt_clk_fail;
    evt_vec[SRC_PIN]  = pin_rise & pin_alt_sel;
    evt_vec[SRC_VEC]  = evt_vec_err;
    evt_vec[SRC_LINK] = evt_link_stuck;
    clr_vec = (wr_en && wr_sel_e'(wr_sel) == WR_FLAG_CLR) ? wr_data : '0;
    set_vec = (wr_en && wr_sel_e'(wr_sel) == WR_EN_SET)   ? wr_data : '0;
  end

  nmi_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(clr_vec), .flag(flags)
  );

  nmi_enable_reg #(.N(NSRC), .RST_VAL(EN_RESET_VAL), .LOCK_MASK(EN_LOCK_MASK)) u_en (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .en(enables)
  );

  assign nmi_req = |(flags & enables);

  // R8
  req_drop_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_req) |-> $past(wr_en && !wr_sel));
  // R10
  pin_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[SRC_PIN]) |-> $past(pin_alt_sel));
  // R7
  vec_en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enables[SRC_VEC]);
endmodule

// File: tb/nmi_src_agg_tb.sv
module nmi_src_agg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_peer_rst = 0, evt_clk_fail = 0, evt_vec_err = 0, evt_link_stuck = 0;
  logic pin_nmi = 0, pin_alt_sel = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [4:0] wr_data = '0;
  logic nmi_req;
  logic [4:0] flags, enables;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference
  logic [4:0] mf, me;
  int p1, p2, p3;

  always #2 clk = ~clk;

  nmi_src_agg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_peer_rst(evt_peer_rst), .evt_clk_fail(evt_clk_fail),
    .evt_vec_err(evt_vec_err), .evt_link_stuck(evt_link_stuck), .pin_nmi(pin_nmi),
    .pin_alt_sel(pin_alt_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nmi_req(nmi_req), .flags(flags), .enables(enables)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf = '0; me = 5'b01111; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      logic [4:0] ev, cl;
      ev = {evt_link_stuck, evt_vec_err, (p2 == 1 && p3 == 0 && pin_alt_sel), evt_clk_fail, evt_peer_rst};
      cl = (wr_en && !wr_sel) ? wr_data : 5'b0;
      mf = (mf & ~cl) | ev;
      if (wr_en && wr_sel) me = me | wr_data;
      me[3] = 1'b1;
      p3 = p2; p2 = p1; p1 = int'(pin_nmi);
    end
  end

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " flags"}, flags, mf);
      chk({phase, " enables"}, enables, me);
      chk({phase, " nmi_req (R8)"}, {4'b0, nmi_req}, {4'b0, |(mf & me)});
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [4:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    phase = "R1";
    chk("R1 flags", flags, 5'b0);
    chk("R1 enables", enables, 5'b01111);
    chk("R1 nmi_req", {4'b0, nmi_req}, 5'b0);

    // R2 clock fail lands in bit 1
    phase = "R2";
    evt_clk_fail = 1; @(negedge clk); evt_clk_fail = 0;
    chk("R2 clk fail bit", flags, 5'b00010);
    chk("R8 req high", {4'b0, nmi_req}, 5'b1);
    idle(2);

    // R4 W1C, partial mask
    phase = "R4";
    evt_peer_rst = 1; @(negedge clk); evt_peer_rst = 0;
    wr(1'b0, 5'b00010);
    chk("R4 partial clear", flags, 5'b00001);
    wr(1'b0, 5'b00001);
    chk("R4 full clear", flags, 5'b0);

    // R3 disabled source still flags
    phase = "R3";
    evt_link_stuck = 1; @(negedge clk); evt_link_stuck = 0;
    chk("R3 flag while disabled", flags, 5'b10000);
    chk("R3 no req", {4'b0, nmi_req}, 5'b0);

    // R6 enable set, sticky
    phase = "R6";
    wr(1'b1, 5'b10000);
    chk("R6 enable set", enables, 5'b11111);
    chk("R6 req now", {4'b0, nmi_req}, 5'b1);
    wr(1'b1, 5'b00000);
    chk("R6 zero write ignored", enables, 5'b11111);
    wr(1'b0, 5'b10000);

    // R5 event beats clear
    phase = "R5";
    evt_vec_err = 1; @(negedge clk); evt_vec_err = 0;
    evt_vec_err = 1; wr_en = 1; wr_sel = 0; wr_data = 5'b01000;
    @(negedge clk);
    evt_vec_err = 0; wr_en = 0; wr_data = '0;
    chk("R5 flag kept", flags, 5'b01000);
    chk("R7 vec enable", {4'b0, enables[3]}, 5'b1);
    wr(1'b0, 5'b01000);

    // R8 req held until all enabled flags cleared
    phase = "R8";
    evt_clk_fail = 1; evt_link_stuck = 1; @(negedge clk);
    evt_clk_fail = 0; evt_link_stuck = 0;
    wr(1'b0, 5'b00010);
    chk("R8 still high", {4'b0, nmi_req}, 5'b1);
    wr(1'b0, 5'b10000);
    chk("R8 low", {4'b0, nmi_req}, 5'b0);

    // R10 pin without selection
    phase = "R10";
    pin_nmi = 1; idle(5); pin_nmi = 0; idle(4);
    chk("R10 pin ignored", flags, 5'b0);

    // R9 pin with selection, edge timing
    phase = "R9";
    pin_alt_sel = 1;
    pin_nmi = 1;
    idle(2);
    chk("R9 not yet", flags, 5'b0);
    idle(1);
    chk("R9 flag at third edge", flags, 5'b00100);
    wr(1'b0, 5'b00100);
    idle(6);
    chk("R9 held pin no refire", flags, 5'b0);
    pin_nmi = 0; idle(4);
    pin_nmi = 1; idle(4);
    chk("R9 second edge", flags, 5'b00100);
    pin_nmi = 0;
    wr(1'b0, 5'b00100);
    idle(4);

    finish_run();
  end
endmodule